// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block stands between an interrupt priority controller and a small CPU datapath. When the controller hands it an accepted request (a priority level and a vector address), it saves a two-word context frame on a software stack in data memory. The frame holds the return program counter, the low byte of the status register and the trap-level bit. The sequencer then raises the CPU priority to the accepted level, acknowledges the controller and redirects instruction fetch to the vector. On a return command it reads the frame back in reverse order, reloads fetch with the saved program counter and restores the earlier status byte and trap bit.

The stack grows upward in byte addresses and holds one 16-bit word per two bytes. Before a frame is written, the sequencer compares the highest address the frame would use against a programmable limit. A frame that does not fit is not written at all, and a one-cycle stack error trap request goes back to the controller. Software can write the status low byte at any time, and the new value reaches the CPU priority output on the next cycle. This is how a handler lowers its own priority. General register saving and instruction decoding belong to other blocks.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset the sequencer is idle (busy_o low), the stack pointer equals the SP_RESET parameter (default 0x0080), the status byte, trap bit and CPU priority are 0, and ack_o, fetch_load_o, mem_we_o, mem_re_o and stk_err_o are low.
- R2: An accepted entry writes two words on consecutive cycles. The first goes to address SP and holds {return PC bits 15..1, trap bit}. The second goes to SP+2 and holds {status byte in bits 15..8, return PC bits 23..16 in bits 7..0}. SP ends 4 higher.
- R3: In the cycle after the second write, the CPU priority output equals the accepted level. The status byte bits 7..5 hold the level's three low bits, and bits 4..0 of the status byte are kept.
- R4: That same cycle is the only one in which ack_o is high. fetch_load_o is high with it and fetch_pc_o equals the supplied vector. After it the sequencer is idle again.
- R5: A return reads address SP-2 and then SP-4 on consecutive cycles. In the second read cycle it loads fetch with {word at SP-2 bits 7..0, word at SP-4 bits 15..1, 0}. At the end of that cycle it restores the status byte from bits 15..8 of the first word and the trap bit from bit 0 of the second word. SP ends 4 lower, and ack_o stays low.
- R6: The trap bit (bit 3 of the CPU priority) becomes 1 on entry only for levels 8 to 15. Levels 1 to 7 leave it 0.
- R7: A status write in an idle cycle appears on sr_o and on the CPU priority output in the next cycle.
- R8: If the entry would need an address above the limit (SP+2 > limit), nothing is written, there is no ack, SP and status are unchanged, the sequencer stays idle, and stk_err_o is high for exactly one cycle.
- R9: take_i and ret_i are ignored while the sequencer is busy.
- R10: If take_i and ret_i are both high in an idle cycle, the entry is performed and the return is dropped.
- R11: A status write in the cycle where the sequencer itself updates the status (the second push cycle or the second pop cycle) is discarded, and the sequencer's value is kept.
- R12: A limit write takes effect for the next entry. A frame whose second word lands exactly on the limit is accepted.
- R13: Nested entries followed by returns restore the program counters, status bytes and trap bits in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| take_i | input | 1 | Controller orders an entry |
| take_lvl_i | input | 4 | Accepted priority level (8..15 are traps) |
| take_vec_i | input | 24 | Handler vector address |
| ret_pc_i | input | 23 | Return PC bits 23..1 (bit 0 is always 0) |
| ret_i | input | 1 | Return-from-interrupt command |
| sr_wr_i | input | 1 | Software write of the status low byte |
| sr_wr_data_i | input | 8 | Status byte value; bits 7..5 are the priority |
| lim_wr_i | input | 1 | Write the stack limit |
| lim_data_i | input | 16 | New stack limit byte address |
| mem_rdata_i | input | 16 | Data memory read word, valid in the same cycle |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_addr_o | output | 16 | Data memory byte address |
| mem_wdata_o | output | 16 | Data memory write word |
| fetch_load_o | output | 1 | Load fetch_pc_o into the fetch unit |
| fetch_pc_o | output | 24 | New fetch address |
| ack_o | output | 1 | Entry completed toward the controller |
| busy_o | output | 1 | Sequence in progress |
| stk_err_o | output | 1 | Stack error trap request (one-cycle pulse) |
| sr_o | output | 8 | Status low byte |
| ipl3_o | output | 1 | Trap priority bit |
| cpu_ipl_o | output | 4 | CPU priority {trap bit, status bits 7..5} |
| sp_o | output | 16 | Stack pointer |

## Verification
A software status write can land in the cycle where the sequencer writes the status itself: the last push of an entry, or the last pop of a return. The bench provokes this by driving sr_wr_i with a value that contradicts the expected one exactly in that cycle. It then judges from sr_o and cpu_ipl_o one cycle later that the raised level or the restored byte survived. A second collision, take_i and ret_i in the same idle cycle, is judged by the write strobes, the ack and a stack pointer that moved up by exactly one frame.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_W = 16;
    localparam int SR_W   = 8;
    localparam int PC_W   = 24;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 16;
    localparam int PRIO_W = LVL_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_VECTOR,
        ST_POP_HI,
        ST_POP_LO
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   sp;
        logic [ADDR_W-1:0]   lim;
        logic [SR_W-1:0]     sr;
        logic                ipl3;
        logic [WORD_W-1:0]   lo;
        logic [WORD_W-1:0]   hi;
        logic [PC_W-1:0]     vec;
        logic [LVL_W-1:0]    lvl;
        logic                err;
    } seq_regs_t;

endpackage

// File: rtl/irq_seq_guard.sv
module irq_seq_guard
    import irq_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] lim_i,
    output logic              room_o
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] top_addr;

    // Highest byte address the two-word frame would occupy.
    always_comb begin
        top_addr = {1'b0, sp_i} + EXT_W'(2);
        room_o   = (top_addr <= {1'b0, lim_i});
    end
endmodule

// File: rtl/irq_seq_frame.sv
module irq_seq_frame
    import irq_seq_pkg::*;
(
    input  logic [PC_W-2:0]   pc_hi23_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic              ipl3_i,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o,
    input  logic [WORD_W-1:0] hi_word_i,
    input  logic [WORD_W-1:0] lo_word_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [SR_W-1:0]   sr_o,
    output logic              ipl3_o
);
    localparam int LO_PC_BITS = WORD_W - 1;
    localparam int HI_PC_BITS = PC_W - WORD_W;

    always_comb begin
        lo_o   = {pc_hi23_i[LO_PC_BITS-1:0], ipl3_i};
        hi_o   = {sr_i, pc_hi23_i[PC_W-2:LO_PC_BITS]};
        pc_o   = {hi_word_i[HI_PC_BITS-1:0], lo_word_i[WORD_W-1:1], 1'b0};
        sr_o   = hi_word_i[WORD_W-1:WORD_W-SR_W];
        ipl3_o = lo_word_i[0];
    end
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] SP_RESET  = 16'h0080,
    parameter logic [15:0] LIM_RESET = 16'h00FE
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        take_i,
    input  logic [3:0]  take_lvl_i,
    input  logic [23:0] take_vec_i,
    input  logic [22:0] ret_pc_i,
    input  logic        ret_i,
    input  logic        sr_wr_i,
    input  logic [7:0]  sr_wr_data_i,
    input  logic        lim_wr_i,
    input  logic [15:0] lim_data_i,
    input  logic [15:0] mem_rdata_i,
    output logic        mem_we_o,
    output logic        mem_re_o,
    output logic [15:0] mem_addr_o,
    output logic [15:0] mem_wdata_o,
    output logic        fetch_load_o,
    output logic [23:0] fetch_pc_o,
    output logic        ack_o,
    output logic        busy_o,
    output logic        stk_err_o,
    output logic [7:0]  sr_o,
    output logic        ipl3_o,
    output logic [3:0]  cpu_ipl_o,
    output logic [15:0] sp_o
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
    localparam int                PRIO_LSB  = SR_W - PRIO_W;

    seq_regs_t r_q, r_d;

    logic              room;
    logic [WORD_W-1:0] pack_lo, pack_hi;
    logic [PC_W-1:0]   pop_pc;
    logic [SR_W-1:0]   pop_sr;
    logic              pop_ipl3;

    irq_seq_guard guard_i (
        .sp_i   (r_q.sp),
        .lim_i  (r_q.lim),
        .room_o (room)
    );

    irq_seq_frame frame_i (
        .pc_hi23_i (ret_pc_i),
        .sr_i      (r_q.sr),
        .ipl3_i    (r_q.ipl3),
        .lo_o      (pack_lo),
        .hi_o      (pack_hi),
        .hi_word_i (r_q.hi),
        .lo_word_i (mem_rdata_i),
        .pc_o      (pop_pc),
        .sr_o      (pop_sr),
        .ipl3_o    (pop_ipl3)
    );

    // Next-state computation.
    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        if (lim_wr_i) r_d.lim = lim_data_i;
        if (sr_wr_i)  r_d.sr  = sr_wr_data_i;
        unique case (r_q.st)
            ST_IDLE: begin
                if (take_i) begin
                    if (room) begin
                        r_d.st  = ST_PUSH_LO;
                        r_d.lo  = pack_lo;
                        r_d.hi  = pack_hi;
                        r_d.vec = take_vec_i;
                        r_d.lvl = take_lvl_i;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end else if (ret_i) begin
                    r_d.st = ST_POP_HI;
                end
            end
            ST_PUSH_LO: begin
                r_d.sp = r_q.sp + WORD_STEP;
                r_d.st = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                r_d.sp   = r_q.sp + WORD_STEP;
                r_d.sr   = {r_q.lvl[PRIO_W-1:0], r_q.sr[PRIO_LSB-1:0]};
                r_d.ipl3 = r_q.lvl[LVL_W-1];
                r_d.st   = ST_VECTOR;
            end
            ST_VECTOR: begin
                r_d.st = ST_IDLE;
            end
            ST_POP_HI: begin
                r_d.sp = r_q.sp - WORD_STEP;
                r_d.hi = mem_rdata_i;
                r_d.st = ST_POP_LO;
            end
            ST_POP_LO: begin
                r_d.sp   = r_q.sp - WORD_STEP;
                r_d.sr   = pop_sr;
                r_d.ipl3 = pop_ipl3;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, sp: SP_RESET, lim: LIM_RESET, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        mem_we_o     = (r_q.st == ST_PUSH_LO) || (r_q.st == ST_PUSH_HI);
        mem_re_o     = (r_q.st == ST_POP_HI)  || (r_q.st == ST_POP_LO);
        mem_addr_o   = mem_we_o ? r_q.sp : (r_q.sp - WORD_STEP);
        mem_wdata_o  = (r_q.st == ST_PUSH_LO) ? r_q.lo : r_q.hi;
        ack_o        = (r_q.st == ST_VECTOR);
        fetch_load_o = ack_o || (r_q.st == ST_POP_LO);
        fetch_pc_o   = ack_o ? r_q.vec : pop_pc;
        busy_o       = (r_q.st != ST_IDLE);
        stk_err_o    = r_q.err;
        sr_o         = r_q.sr;
        ipl3_o       = r_q.ipl3;
        cpu_ipl_o    = {r_q.ipl3, r_q.sr[SR_W-1:PRIO_LSB]};
        sp_o         = r_q.sp;
    end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        fetch_load_o,
    input logic        ack_o,
    input logic        busy_o,
    input logic        stk_err_o,
    input logic [15:0] sp_o
);
    assert_push_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> (sp_o == $past(sp_o) + 16'd2));

    assert_ack_after_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(mem_we_o));

    assert_ack_fetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> fetch_load_o);

    assert_ack_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> (!ack_o && !busy_o));

    assert_pop_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_re_o |=> (sp_o == $past(sp_o) - 16'd2));

    assert_pop_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_load_o && !ack_o) |-> mem_re_o);

    assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stk_err_o |-> (!busy_o && !mem_we_o && $stable(sp_o)));

    assert_no_rw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_we_o && mem_re_o));
endmodule

bind irq_frame_seq irq_seq_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .fetch_load_o (fetch_load_o),
    .ack_o        (ack_o),
    .busy_o       (busy_o),
    .stk_err_o    (stk_err_o),
    .sp_o         (sp_o)
);

// File: tb/irq_frame_seq_tb_top.sv
module irq_frame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [3:0]  take_lvl = '0;
    logic [23:0] take_vec = '0;
    logic [22:0] ret_pc = '0;
    logic        ret = 1'b0;
    logic        sr_wr = 1'b0;
    logic [7:0]  sr_wr_data = '0;
    logic        lim_wr = 1'b0;
    logic [15:0] lim_data = '0;
    logic [15:0] mem_rdata;
    logic        mem_we, mem_re, fetch_load, ack, busy, stk_err, ipl3;
    logic [15:0] mem_addr, mem_wdata, sp;
    logic [23:0] fetch_pc;
    logic [7:0]  sr;
    logic [3:0]  cpu_ipl;

    logic [15:0] mem [0:255];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] e_sp;
    logic [7:0]  e_sr;
    logic        e_ipl3;
    logic [22:0] s_pc   [0:7];
    logic [7:0]  s_sr   [0:7];
    logic        s_ipl3 [0:7];
    int          depth = 0;

    always #10 clk = ~clk;

    irq_frame_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .take_i(take), .take_lvl_i(take_lvl), .take_vec_i(take_vec),
        .ret_pc_i(ret_pc), .ret_i(ret),
        .sr_wr_i(sr_wr), .sr_wr_data_i(sr_wr_data),
        .lim_wr_i(lim_wr), .lim_data_i(lim_data),
        .mem_rdata_i(mem_rdata),
        .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .fetch_load_o(fetch_load), .fetch_pc_o(fetch_pc),
        .ack_o(ack), .busy_o(busy), .stk_err_o(stk_err),
        .sr_o(sr), .ipl3_o(ipl3), .cpu_ipl_o(cpu_ipl), .sp_o(sp)
    );

    assign mem_rdata = mem[mem_addr[8:1]];
    always @(posedge clk) if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 sp", sp, 16'h0080);
        chk("R1 sr", sr, 0);
        chk("R1 ipl", cpu_ipl, 0);
        chk("R1 strobes", {ack, fetch_load, mem_we, mem_re, stk_err}, 0);
        e_sp = 16'h0080; e_sr = 8'h00; e_ipl3 = 1'b0;
    endtask

    task automatic t_sr_write(input logic [7:0] v);
        @(negedge clk); sr_wr = 1'b1; sr_wr_data = v;
        @(negedge clk); sr_wr = 1'b0;
        chk("R7 sr", sr, v);
        chk("R7 ipl", cpu_ipl, {e_ipl3, v[7:5]});
        e_sr = v;
    endtask

    // Entry; coll = contradicting status write in last push cycle (R11),
    // busy_take = second take while busy (R9), with_ret = ret in same cycle (R10).
    task automatic t_take(input logic [3:0] lvl, input logic [23:0] vec, input logic [22:0] pc,
                          input bit coll, input bit busy_take, input bit with_ret);
        logic [15:0] sp0, lo_e, hi_e;
        sp0 = e_sp;
        lo_e = {pc[14:0], e_ipl3};
        hi_e = {e_sr, pc[22:15]};
        @(negedge clk); take = 1'b1; take_lvl = lvl; take_vec = vec; ret_pc = pc; ret = with_ret;
        @(negedge clk); take = busy_take; ret = 1'b0; take_lvl = 4'd1;
        chk("R2 first we", mem_we, 1);
        chk("R2 first addr", mem_addr, sp0);
        chk("R2 first word", mem_wdata, lo_e);
        @(negedge clk); take = 1'b0;
        chk("R2 second addr", mem_addr, sp0 + 16'd2);
        chk("R2 second word", mem_wdata, hi_e);
        chk("R3 ipl not yet", cpu_ipl, {e_ipl3, e_sr[7:5]});
        if (coll) begin sr_wr = 1'b1; sr_wr_data = ~{lvl[2:0], e_sr[4:0]}; end
        @(negedge clk); sr_wr = 1'b0;
        chk("R4 ack", ack, 1);
        chk("R4 fetch load", fetch_load, 1);
        chk("R4 vector", fetch_pc, vec);
        chk("R3 level", cpu_ipl, lvl);
        chk("R6 trap bit", ipl3, lvl[3]);
        if (coll) chk("R11 entry status", sr, {lvl[2:0], e_sr[4:0]});
        s_pc[depth] = pc; s_sr[depth] = e_sr; s_ipl3[depth] = e_ipl3; depth++;
        e_sr = {lvl[2:0], e_sr[4:0]}; e_ipl3 = lvl[3]; e_sp = sp0 + 16'd4;
        @(negedge clk);
        chk("R4 idle after", {busy, ack}, 0);
        chk("R2 sp", sp, e_sp);
        chk("R2 mem lo", mem[sp0[8:1]], lo_e);
        chk("R2 mem hi", mem[sp0[8:1] + 8'd1], hi_e);
        if (busy_take) chk("R9 take ignored", {busy, mem_we}, 0);
        if (with_ret)  chk("R10 take wins", {busy, mem_re}, 0);
    endtask

    task automatic t_ret(input bit coll, input bit busy_ret);
        logic [15:0] sp0;
        depth--;
        sp0 = e_sp;
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = busy_ret;
        chk("R5 first re", mem_re, 1);
        chk("R5 first addr", mem_addr, sp0 - 16'd2);
        @(negedge clk); ret = 1'b0;
        chk("R5 second addr", mem_addr, sp0 - 16'd4);
        chk("R5 fetch load", {fetch_load, ack}, 2'b10);
        chk("R13 return pc", fetch_pc, {s_pc[depth], 1'b0});
        if (coll) begin sr_wr = 1'b1; sr_wr_data = ~s_sr[depth]; end
        @(negedge clk); sr_wr = 1'b0;
        e_sp = sp0 - 16'd4; e_sr = s_sr[depth]; e_ipl3 = s_ipl3[depth];
        chk("R5 idle", busy, 0);
        chk("R5 sp", sp, e_sp);
        chk("R13 sr restored", sr, e_sr);
        chk("R13 ipl3 restored", ipl3, e_ipl3);
        if (coll) chk("R11 return status", cpu_ipl, {e_ipl3, e_sr[7:5]});
        @(negedge clk);
        if (busy_ret) chk("R9 ret ignored", {busy, mem_re, sp}, {2'b00, e_sp});
    endtask

    task automatic t_overflow();
        @(negedge clk); lim_wr = 1'b1; lim_data = e_sp;
        @(negedge clk); lim_wr = 1'b0; take = 1'b1; take_lvl = 4'd6; take_vec = 24'h000200;
        @(negedge clk); take = 1'b0;
        chk("R8 err pulse", stk_err, 1);
        chk("R8 no write", {busy, mem_we}, 0);
        @(negedge clk);
        chk("R8 single pulse", {stk_err, ack, busy}, 0);
        chk("R8 sp kept", sp, e_sp);
        chk("R8 ipl kept", cpu_ipl, {e_ipl3, e_sr[7:5]});
        // Exact fit: second word on the limit.
        @(negedge clk); lim_wr = 1'b1; lim_data = e_sp + 16'd2;
        @(negedge clk); lim_wr = 1'b0;
        t_take(4'd6, 24'h000240, 23'h001234, 0, 0, 0);
        chk("R12 boundary no err", stk_err, 0);
        t_ret(0, 0);
        @(negedge clk); lim_wr = 1'b1; lim_data = 16'h00FE;
        @(negedge clk); lim_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sr_write(8'h45);
        t_sr_write(8'h05);
        t_take(4'd3, 24'h000014, 23'h2A5A5A, 0, 1, 0);
        t_take(4'd13, 24'h00000C, 23'h055AA3, 1, 0, 0);
        t_take(4'd7, 24'h000030, 23'h7FFFFF, 0, 0, 1);
        t_ret(1, 0);
        t_ret(0, 1);
        t_sr_write(8'h25);
        t_ret(1, 0);
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule